// File: doc/BRIEF.md
# Integer Twin Butterfly Rounding Unit

This block is a pipelined integer datapath for the butterfly step of forward DCT transforms in video coding. Each issue takes two signed operands `a` and `b`, one signed coefficient `c` and a shift amount `n`. It returns two results at the same time. The sum leg is `(a+b)*c` and the difference leg is `(a-b)*c`. Each leg keeps the low XLEN bits of its signed product and is then shifted right arithmetically by `n`, rounding half up.

The block accepts one issue per cycle. Every issue comes out exactly three cycles after it is accepted, as long as the output is being consumed. Both edges of the block use a valid/ready handshake. When the consumer stalls, the pipeline stalls, and the output results stay frozen.

A two-coefficient butterfly `a*c1 ± b*c2` is built from two issues and accumulated outside the block. The first issue uses `(a, b, c1)`. The second issue swaps the operands and uses the second constant, `(b, a, c2)`.

Top module: `bfly_round_unit`

## Requirements
- R1: `out_hi` equals the rounded shift of the low XLEN bits of the signed product `(in_a + in_b) * in_coef`. Operands and results are two's-complement.
- R2: `out_lo` equals the rounded shift of the low XLEN bits of the signed product `(in_a - in_b) * in_coef`. It comes from the same issue as `out_hi`.
- R3: The sum and difference are formed without overflow. Only the product is truncated, to its low XLEN bits. The result wraps modulo 2^XLEN.
- R4: For `in_shift` = n ≥ 1, the result is `(p + 2^(n-1)) >>> n` taken modulo 2^XLEN, where p is the truncated product and `>>>` is an arithmetic shift. Ties round toward plus infinity, so -3 with n=1 gives -1 and 3 with n=1 gives 2.
- R5: For `in_shift` = 0, the result is the truncated product, with no increment added.
- R6: `in_shift` is 5 bits wide and unsigned, and covers 0 to 31. The value 31 is handled correctly.
- R7: When `out_ready` is held high, a result appears on `out_valid` three clock cycles after its issue is accepted (`in_valid && in_ready` at a clock edge).
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_hi` and `out_lo` hold steady. No issue is lost or duplicated.
- R9: Results leave the block in the order their issues were accepted. Random stalls on either side do not change this order.
- R10: After a synchronous active-high `rst`, `out_valid` is 0 and `in_ready` is 1.
- R11: Swapping `in_a` and `in_b` leaves `out_hi` unchanged and gives the rounded shift of `(in_b - in_a) * in_coef` on `out_lo`. This is the second issue of a two-coefficient butterfly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue is presented |
| in_ready | output | 1 | Block can take an issue this cycle |
| in_a | input | XLEN | Signed operand a |
| in_b | input | XLEN | Signed operand b |
| in_coef | input | XLEN | Signed coefficient |
| in_shift | input | 5 | Right shift amount n, 0 to 31 |
| out_valid | output | 1 | Result pair is present |
| out_ready | input | 1 | Consumer takes the result pair |
| out_hi | output | XLEN | Rounded sum-leg result |
| out_lo | output | XLEN | Rounded difference-leg result |

## Verification
The bench applies shifts of 0, 1, 14 and 31. A design that adds the rounding bit at n=0, or indexes bit n-1 wrongly at the ends of the range, gives results that are off by one.

It uses negative values that land exactly on a half step to tell round-half-up apart from truncation or rounding toward zero. It uses extreme operands whose sum overflows XLEN bits and a coefficient of -1 to catch a narrow adder or an unsigned multiply.

Random stalls on both sides expose results that are dropped, duplicated or reordered, and outputs that change while stalled. Operand-swap pairs check the second issue of the two-coefficient butterfly.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int unsigned SH_W = 5;
  typedef logic [SH_W-1:0] shamt_t;
  localparam int unsigned N_LEGS = 2;
  localparam int unsigned LEG_SUM  = 0;
  localparam int unsigned LEG_DIFF = 1;
endpackage

// File: rtl/bfly_addsub_stage.sv
module bfly_addsub_stage
  import bfly_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [XLEN-1:0]        a,
  input  logic [XLEN-1:0]        b,
  input  logic [XLEN-1:0]        coef,
  input  shamt_t                 shift,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic signed [XLEN:0]   sum_q,
  output logic signed [XLEN:0]   diff_q,
  output logic [XLEN-1:0]        coef_q,
  output shamt_t                 shift_q
);
  localparam int unsigned WW = XLEN + 1;

  logic signed [WW-1:0] a_x, b_x;
  logic                 load;
  logic                 v_q;

  assign a_x      = $signed({a[XLEN-1], a});
  assign b_x      = $signed({b[XLEN-1], b});
  assign in_ready = !v_q || out_ready;
  assign load     = in_valid && in_ready;
  assign out_valid = v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (load) begin
      v_q <= 1'b1;
    end else if (out_ready) begin
      v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      sum_q   <= a_x + b_x;
      diff_q  <= a_x - b_x;
      coef_q  <= coef;
      shift_q <= shift;
    end
  end

  // R3: the widened legs recombine exactly to twice each operand
  a_r3_legs_exact: assert property (@(posedge clk) disable iff (rst)
    load |=> ({sum_q[XLEN], sum_q} + {diff_q[XLEN], diff_q}) ==
             {$past(a[XLEN-1]), $past(a), 1'b0});
endmodule

// File: rtl/bfly_mul_stage.sv
module bfly_mul_stage
  import bfly_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [XLEN:0] sum_i,
  input  logic signed [XLEN:0] diff_i,
  input  logic [XLEN-1:0]      coef_i,
  input  shamt_t               shift_i,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [XLEN-1:0]      prod_q [N_LEGS],
  output shamt_t               shift_q
);
  localparam int unsigned PW = 2 * XLEN + 2;

  logic signed [XLEN:0]   coef_x;
  logic signed [XLEN:0]   leg_in [N_LEGS];
  logic signed [PW-1:0]   full   [N_LEGS];
  logic                   load;
  logic                   v_q;

  assign coef_x          = $signed({coef_i[XLEN-1], coef_i});
  assign leg_in[LEG_SUM]  = sum_i;
  assign leg_in[LEG_DIFF] = diff_i;
  assign in_ready  = !v_q || out_ready;
  assign load      = in_valid && in_ready;
  assign out_valid = v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (load) begin
      v_q <= 1'b1;
    end else if (out_ready) begin
      v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) shift_q <= shift_i;
  end

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    always_comb full[g] = leg_in[g] * coef_x;
    always_ff @(posedge clk) begin
      if (load) prod_q[g] <= full[g][XLEN-1:0];
    end
  end

  // R8: a stalled stage keeps its contents
  a_r8_mul_hold: assert property (@(posedge clk) disable iff (rst)
    (v_q && !out_ready) |=> v_q && $stable(prod_q[LEG_SUM]) && $stable(prod_q[LEG_DIFF]));
endmodule

// File: rtl/bfly_rounder.sv
module bfly_rounder
  import bfly_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] p,
  input  shamt_t          shift,
  output logic [XLEN-1:0] r
);
  logic signed [XLEN-1:0] shifted;
  shamt_t                 pick;
  logic                   inc;

  always_comb begin
    shifted = $signed(p) >>> shift;
    pick    = shift - 1'b1;
    inc     = (shift != '0) && p[pick];
    r       = shifted + {{(XLEN-1){1'b0}}, inc};
  end
endmodule

// File: rtl/bfly_round_stage.sv
module bfly_round_stage
  import bfly_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] prod_i [N_LEGS],
  input  shamt_t          shift_i,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] res_q  [N_LEGS]
);
  logic [XLEN-1:0] rnd [N_LEGS];
  logic            load;
  logic            v_q;

  assign in_ready  = !v_q || out_ready;
  assign load      = in_valid && in_ready;
  assign out_valid = v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (load) begin
      v_q <= 1'b1;
    end else if (out_ready) begin
      v_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    bfly_rounder #(.XLEN(XLEN)) u_rnd (
      .p     (prod_i[g]),
      .shift (shift_i),
      .r     (rnd[g])
    );
    always_ff @(posedge clk) begin
      if (load) res_q[g] <= rnd[g];
    end
  end

  // R5: a zero shift passes the truncated product through
  a_r5_zero_shift: assert property (@(posedge clk) disable iff (rst)
    (load && shift_i == '0) |=> res_q[LEG_SUM] == $past(prod_i[LEG_SUM]) &&
                               res_q[LEG_DIFF] == $past(prod_i[LEG_DIFF]));
  // R4: an odd product shifted by one rounds up by one half step
  a_r4_half_up: assert property (@(posedge clk) disable iff (rst)
    (load && shift_i == 5'd1 && prod_i[LEG_SUM][0]) |=>
      res_q[LEG_SUM] == (($past(prod_i[LEG_SUM]) + 1'b1) >> 1 |
                         {$past(prod_i[LEG_SUM][XLEN-1]) && !(&$past(prod_i[LEG_SUM])), {(XLEN-1){1'b0}}}));
endmodule

// File: rtl/bfly_round_unit.sv
module bfly_round_unit
  import bfly_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   in_a,
  input  logic [XLEN-1:0]   in_b,
  input  logic [XLEN-1:0]   in_coef,
  input  logic [SH_W-1:0]   in_shift,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_hi,
  output logic [XLEN-1:0]   out_lo
);
  logic signed [XLEN:0] s1_sum, s1_diff;
  logic [XLEN-1:0]      s1_coef;
  shamt_t               s1_shift, s2_shift;
  logic                 s1_v, s2_v, s2_rdy, s3_rdy;
  logic [XLEN-1:0]      s2_prod [N_LEGS];
  logic [XLEN-1:0]      s3_res  [N_LEGS];

  bfly_addsub_stage #(.XLEN(XLEN)) u_s1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .a(in_a), .b(in_b), .coef(in_coef), .shift(in_shift),
    .out_valid(s1_v), .out_ready(s2_rdy),
    .sum_q(s1_sum), .diff_q(s1_diff), .coef_q(s1_coef), .shift_q(s1_shift)
  );

  bfly_mul_stage #(.XLEN(XLEN)) u_s2 (
    .clk(clk), .rst(rst), .in_valid(s1_v), .in_ready(s2_rdy),
    .sum_i(s1_sum), .diff_i(s1_diff), .coef_i(s1_coef), .shift_i(s1_shift),
    .out_valid(s2_v), .out_ready(s3_rdy),
    .prod_q(s2_prod), .shift_q(s2_shift)
  );

  bfly_round_stage #(.XLEN(XLEN)) u_s3 (
    .clk(clk), .rst(rst), .in_valid(s2_v), .in_ready(s3_rdy),
    .prod_i(s2_prod), .shift_i(s2_shift),
    .out_valid(out_valid), .out_ready(out_ready), .res_q(s3_res)
  );

  assign out_hi = s3_res[LEG_SUM];
  assign out_lo = s3_res[LEG_DIFF];

  // R8: a stalled result is held at the output
  a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_hi) && $stable(out_lo));
  // R7: an accepted issue occupies the first stage on the next cycle
  a_r7_enter: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> s1_v);
  // R9: with all stages full and the output stalled, no issue is taken
  a_r9_full_stall: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s2_v && out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/sim_bfly_round_unit.sv
module sim_bfly_round_unit;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [XLEN-1:0] in_a = '0, in_b = '0, in_coef = '0;
  logic [4:0] in_shift = '0;
  logic [XLEN-1:0] out_hi, out_lo;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [XLEN-1:0] q_hi[$], q_lo[$];

  always #5 clk = ~clk;

  bfly_round_unit #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_coef(in_coef), .in_shift(in_shift),
    .out_valid(out_valid), .out_ready(out_ready), .out_hi(out_hi), .out_lo(out_lo)
  );

  // Reference: product at full width, truncate, then add half step and shift.
  function automatic logic [XLEN-1:0] ref_leg(input logic [XLEN-1:0] a, b, c,
                                               input logic [4:0] n, input bit sub);
    logic signed [2*XLEN+3:0] wa, wb, wc, full, t;
    logic signed [XLEN+1:0] p, half, rr;
    wa = $signed(a); wb = $signed(b); wc = $signed(c);
    full = (sub ? (wa - wb) : (wa + wb)) * wc;
    p = $signed(full[XLEN-1:0]);
    half = (n == 0) ? '0 : ((XLEN+2)'(1) << (n - 1));
    t = 0;
    rr = (p + half) >>> n;
    return rr[XLEN-1:0];
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [XLEN-1:0] pick_val();
    case ($urandom % 8)
      0: return {1'b0, {(XLEN-1){1'b1}}};
      1: return {1'b1, {(XLEN-1){1'b0}}};
      2: return '1;
      3: return XLEN'($urandom % 64) - XLEN'(32);
      default: return rnd64();
    endcase
  endfunction

  function automatic logic [4:0] pick_n();
    case ($urandom % 6)
      0: return 5'd0;
      1: return 5'd1;
      2: return 5'd14;
      3: return 5'd31;
      default: return 5'($urandom);
    endcase
  endfunction

  // Single issue on an empty pipe; measures latency (R7).
  task automatic run_one(input logic [XLEN-1:0] a, b, c, input logic [4:0] n,
                         output logic [XLEN-1:0] hi, lo);
    int cnt;
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1;
    in_a = a; in_b = b; in_coef = c; in_shift = n;
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 1;
    while (!out_valid && cnt < 10) begin
      @(negedge clk);
      cnt++;
    end
    check("R7 latency", XLEN'(cnt), XLEN'(3));
    hi = out_hi; lo = out_lo;
  endtask

  task automatic directed(input string req, input logic [XLEN-1:0] a, b, c,
                          input logic [4:0] n);
    logic [XLEN-1:0] hi, lo;
    run_one(a, b, c, n, hi, lo);
    check({req, " R1 hi"}, hi, ref_leg(a, b, c, n, 0));
    check({req, " R2 lo"}, lo, ref_leg(a, b, c, n, 1));
  endtask

  initial begin
    int guard = 0;
    while (!finished && guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", guard);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] h1, l1, h2, l2, hold_hi, hold_lo;
    bit holding;
    int sent, got;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R10 out_valid after reset", XLEN'(out_valid), XLEN'(0));
    check("R10 in_ready after reset", XLEN'(in_ready), XLEN'(1));

    // R4: -3 >> 1 -> -1 ; 3 >> 1 -> 2
    directed("R4 neg tie", XLEN'(-3), '0, XLEN'(1), 5'd1);
    check("R4 neg tie value", out_hi, '1);
    directed("R4 pos tie", XLEN'(3), '0, XLEN'(1), 5'd1);
    check("R4 pos tie value", out_hi, XLEN'(2));
    // R5: zero shift passes product untouched
    directed("R5 n0", XLEN'(7), XLEN'(2), XLEN'(-5), 5'd0);
    check("R5 value", out_hi, XLEN'(-45));
    directed("R6 n31", {1'b0, {(XLEN-1){1'b1}}}, XLEN'(12345), XLEN'(777), 5'd31);
    directed("R6 n31 neg", XLEN'(-64'sd3221225472), XLEN'(0), XLEN'(1), 5'd31);
    check("R6 n31 neg value", out_hi, XLEN'(-1));
    // R3: sum overflows XLEN bits, coefficient -1
    directed("R3 wrap", {1'b0, {(XLEN-1){1'b1}}}, {1'b0, {(XLEN-1){1'b1}}}, '1, 5'd14);
    directed("R3 min", {1'b1, {(XLEN-1){1'b0}}}, XLEN'(1), '1, 5'd0);
    directed("R1 dct", XLEN'(1000), XLEN'(-250), XLEN'(11585), 5'd14);

    // R11: swapped operands
    run_one(XLEN'(40000), XLEN'(-1234), XLEN'(15137), 5'd14, h1, l1);
    run_one(XLEN'(-1234), XLEN'(40000), XLEN'(15137), 5'd14, h2, l2);
    check("R11 hi unchanged", h2, h1);
    check("R11 lo swapped", l2, ref_leg(XLEN'(-1234), XLEN'(40000), XLEN'(15137), 5'd14, 1));

    // Random streaming with stalls (R1, R2, R8, R9)
    sent = 0; got = 0; holding = 0;
    @(negedge clk);
    while (got < 3000) begin
      out_ready = ($urandom % 4) != 0;
      if (holding) begin
        check("R8 hold hi", out_hi, hold_hi);
        check("R8 hold lo", out_lo, hold_lo);
        check("R8 hold valid", XLEN'(out_valid), XLEN'(1));
      end
      if (out_valid && out_ready) begin
        if (q_hi.size() == 0) begin
          check("R9 unexpected output", XLEN'(1), XLEN'(0));
        end else begin
          check("R1/R9 hi", out_hi, q_hi.pop_front());
          check("R2/R9 lo", out_lo, q_lo.pop_front());
        end
        got++;
      end
      holding = out_valid && !out_ready;
      hold_hi = out_hi; hold_lo = out_lo;
      if (!in_valid || in_ready) begin
        in_valid = (sent < 3000) && (($urandom % 3) != 0);
        in_a = pick_val(); in_b = pick_val(); in_coef = pick_val();
        in_shift = pick_n();
      end
      #1;
      if (in_valid && in_ready) begin
        q_hi.push_back(ref_leg(in_a, in_b, in_coef, in_shift, 0));
        q_lo.push_back(ref_leg(in_a, in_b, in_coef, in_shift, 1));
        sent++;
        if (sent == 3000) begin
          @(negedge clk);
          in_valid = 1'b0;
          #0;
          continue;
        end
      end
      @(negedge clk);
    end
    check("R9 queue drained", XLEN'(q_hi.size()), XLEN'(0));
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule